// File: doc/BRIEF.md
# Signed Extremes Tracker with Clear-on-Read

This block watches a stream of signed conversion results arriving from up to eight input channels. It keeps the largest and the smallest value seen so far. With each extreme it also stores the number of the channel that produced it. Each extreme is shown as a packed read-only status word. The value sits in the upper field, the channel tag in the lowest bits, and the bits between read as zero.

Reading a status word returns its current contents. On the clock edge that ends the read strobe, that tracker is re-armed to the value at the opposite end of the range, and its tag goes to zero. Software can therefore collect the peak-to-peak excursion over one observation window and start the next window with no separate clear. The two trackers run independently. One sample can move both of them.

Top module: `xd_extremes`

## Requirements
- R1: After synchronous reset, the maximum word reads 0x80000000 and the minimum word reads 0x7FFFFF00.
- R2: Each status word carries the 24-bit extreme value in bits 31:8 and the 3-bit channel tag in bits 2:0. Bits 7:3 always read zero.
- R3: A valid sample whose signed value is strictly greater than the stored maximum replaces it, and its channel number becomes the maximum tag on the next clock edge.
- R4: A valid sample whose signed value is strictly less than the stored minimum replaces it, and its channel number becomes the minimum tag on the next clock edge.
- R5: A valid sample equal to a stored extreme leaves both the value and the tag of that extreme unchanged. This also holds when the sample equals a start value.
- R6: While the maximum read strobe is high, the maximum word shows the stored contents. At the edge that ends the strobe, the maximum reloads to 0x800000 with tag 0.
- R7: While the minimum read strobe is high, the minimum word shows the stored contents. At the edge that ends the strobe, the minimum reloads to 0x7FFFFF with tag 0.
- R8: If a valid sample arrives in the same cycle as a read, the read still shows the pre-sample contents. After the edge, the tracker holds that sample and its tag whenever the sample strictly beats the start value.
- R9: The trackers are independent. One sample may update both of them, and reading one word leaves the other word unchanged.
- R10: While the sample-valid strobe is low, the sample and channel inputs have no effect on either word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; high when smp_data and smp_chan hold a result |
| smp_data | input | 24 | Signed conversion result |
| smp_chan | input | 3 | Channel that produced the sample |
| rd_max | input | 1 | Read strobe for the maximum word (re-arms the maximum tracker) |
| rd_min | input | 1 | Read strobe for the minimum word (re-arms the minimum tracker) |
| max_word | output | 32 | Packed maximum value and tag |
| min_word | output | 32 | Packed minimum value and tag |

## Verification
The bench builds the block with its default widths: a 24-bit value, a 3-bit tag and a 32-bit word. At these widths the exact endpoints 0x800000 and 0x7FFFFF can be driven as samples. This reaches the corner where a sample equals a start value and must not displace it. All eight channel numbers, including tag 7 and tag 0, can be told apart in the tag field. The five-bit zero gap between the fields is exercised, and any leakage of value or tag bits into it would show.

// File: rtl/xd_pkg.sv
`timescale 1ns/1ps
package xd_pkg;

    // Which end of the range a tracker follows.
    typedef enum logic {
        TRK_MAX = 1'b0,
        TRK_MIN = 1'b1
    } trk_kind_e;

    // Default geometry of the status words.
    localparam int XD_DATA_W = 24;
    localparam int XD_CH_W   = 3;
    localparam int XD_WORD_W = 32;

    // Most negative and most positive values of a signed field, at the default width.
    function automatic logic [XD_DATA_W-1:0] most_neg();
        return {1'b1, {(XD_DATA_W-1){1'b0}}};
    endfunction

    function automatic logic [XD_DATA_W-1:0] most_pos();
        return {1'b0, {(XD_DATA_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/xd_cmp.sv
`timescale 1ns/1ps
// Strict signed comparator; the direction is chosen by KIND.
module xd_cmp
    import xd_pkg::*;
#(
    parameter int        DATA_W = XD_DATA_W,
    parameter trk_kind_e KIND   = TRK_MAX
) (
    input  logic [DATA_W-1:0] cand,
    input  logic [DATA_W-1:0] base,
    output logic              beats
);

    logic signed [DATA_W-1:0] cand_s;
    logic signed [DATA_W-1:0] base_s;

    assign cand_s = cand;
    assign base_s = base;

    generate
        if (KIND == TRK_MAX) begin : g_gt
            assign beats = (cand_s > base_s);
        end else begin : g_lt
            assign beats = (cand_s < base_s);
        end
    endgenerate

endmodule

// File: rtl/xd_tracker.sv
`timescale 1ns/1ps
// One extreme tracker: a value register, a tag register and re-arm on read.
module xd_tracker
    import xd_pkg::*;
#(
    parameter int        DATA_W = XD_DATA_W,
    parameter int        CH_W   = XD_CH_W,
    parameter trk_kind_e KIND   = TRK_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [CH_W-1:0]   smp_chan,
    input  logic              rd,
    output logic [DATA_W-1:0] val_o,
    output logic [CH_W-1:0]   tag_o
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic [CH_W-1:0]   tag;
    } entry_t;

    localparam logic [DATA_W-1:0] START_VAL = (KIND == TRK_MAX)
        ? {1'b1, {(DATA_W-1){1'b0}}}
        : {1'b0, {(DATA_W-1){1'b1}}};

    localparam entry_t START_ENTRY = '{val: START_VAL, tag: '0};

    entry_t cur_q;
    entry_t base;
    entry_t nxt;
    logic   wins;

    // A read re-arms the tracker, so a sample that arrives with it
    // competes against the start value instead of the stored value.
    assign base = rd ? START_ENTRY : cur_q;

    xd_cmp #(
        .DATA_W (DATA_W),
        .KIND   (KIND)
    ) u_cmp (
        .cand  (smp_data),
        .base  (base.val),
        .beats (wins)
    );

    always_comb begin
        nxt = base;
        if (smp_valid && wins) begin
            nxt.val = smp_data;
            nxt.tag = smp_chan;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= START_ENTRY;
        end else begin
            cur_q <= nxt;
        end
    end

    assign val_o = cur_q.val;
    assign tag_o = cur_q.tag;

endmodule

// File: rtl/xd_word_pack.sv
`timescale 1ns/1ps
// Packs a value and a tag into one status word; the bits between them are zero.
module xd_word_pack
    import xd_pkg::*;
#(
    parameter int DATA_W = XD_DATA_W,
    parameter int CH_W   = XD_CH_W,
    parameter int WORD_W = XD_WORD_W
) (
    input  logic [DATA_W-1:0] val,
    input  logic [CH_W-1:0]   tag,
    output logic [WORD_W-1:0] word
);

    localparam int PAD_W = WORD_W - DATA_W - CH_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {val, {PAD_W{1'b0}}, tag};
        end else begin : g_tight
            assign word = {val, tag};
        end
    endgenerate

endmodule

// File: rtl/xd_extremes.sv
`timescale 1ns/1ps
// Signed running maximum/minimum tracker with channel tags and clear-on-read.
module xd_extremes
    import xd_pkg::*;
#(
    parameter int DATA_W = XD_DATA_W,
    parameter int CH_W   = XD_CH_W,
    parameter int WORD_W = XD_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [CH_W-1:0]   smp_chan,
    input  logic              rd_max,
    input  logic              rd_min,
    output logic [WORD_W-1:0] max_word,
    output logic [WORD_W-1:0] min_word
);

    localparam int NUM_TRK = 2;

    logic [DATA_W-1:0] trk_val [NUM_TRK];
    logic [CH_W-1:0]   trk_tag [NUM_TRK];
    logic [WORD_W-1:0] trk_word[NUM_TRK];
    logic              trk_rd  [NUM_TRK];

    assign trk_rd[0] = rd_max;
    assign trk_rd[1] = rd_min;

    generate
        for (genvar i = 0; i < NUM_TRK; i++) begin : g_trk
            xd_tracker #(
                .DATA_W (DATA_W),
                .CH_W   (CH_W),
                .KIND   ((i == 0) ? TRK_MAX : TRK_MIN)
            ) u_trk (
                .clk       (clk),
                .rst       (rst),
                .smp_valid (smp_valid),
                .smp_data  (smp_data),
                .smp_chan  (smp_chan),
                .rd        (trk_rd[i]),
                .val_o     (trk_val[i]),
                .tag_o     (trk_tag[i])
            );

            xd_word_pack #(
                .DATA_W (DATA_W),
                .CH_W   (CH_W),
                .WORD_W (WORD_W)
            ) u_pack (
                .val  (trk_val[i]),
                .tag  (trk_tag[i]),
                .word (trk_word[i])
            );
        end
    endgenerate

    assign max_word = trk_word[0];
    assign min_word = trk_word[1];

endmodule

// File: rtl/xd_extremes_chk.sv
`timescale 1ns/1ps
module xd_extremes_chk
    import xd_pkg::*;
#(
    parameter int DATA_W = XD_DATA_W,
    parameter int CH_W   = XD_CH_W,
    parameter int WORD_W = XD_WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic [CH_W-1:0]   smp_chan,
    input logic              rd_max,
    input logic              rd_min,
    input logic [WORD_W-1:0] max_word,
    input logic [WORD_W-1:0] min_word
);

    localparam int PAD_W = WORD_W - DATA_W - CH_W;
    localparam logic [WORD_W-1:0] MAX_RST = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] MIN_RST = {1'b0, {(DATA_W-1){1'b1}}, {(WORD_W-DATA_W){1'b0}}};

    logic signed [DATA_W-1:0] max_v;
    logic signed [DATA_W-1:0] min_v;
    logic                     rst_seen_q;

    assign max_v = max_word[WORD_W-1 -: DATA_W];
    assign min_v = min_word[WORD_W-1 -: DATA_W];

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1: reset values of both words
    always_ff @(posedge clk) begin
        if (rst_seen_q && !rst) begin
            p_reset_words_r1: assert (max_word == MAX_RST && min_word == MIN_RST)
                else $error("R1 reset words wrong");
        end
    end

    // R2: the gap between value and tag stays zero
    generate
        if (PAD_W > 0) begin : g_pad_chk
            p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
                (max_word[CH_W +: PAD_W] == '0) && (min_word[CH_W +: PAD_W] == '0));
        end
    endgenerate

    // R3: without a read the maximum never decreases
    p_max_mono_r3: assert property (@(posedge clk) disable iff (rst)
        !rd_max |=> (max_v >= $signed($past(max_v))));

    // R4: without a read the minimum never increases
    p_min_mono_r4: assert property (@(posedge clk) disable iff (rst)
        !rd_min |=> (min_v <= $signed($past(min_v))));

    // R6: a read with no sample re-arms the maximum
    p_max_rearm_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_max && !smp_valid) |=> (max_word == MAX_RST));

    // R7: a read with no sample re-arms the minimum
    p_min_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_min && !smp_valid) |=> (min_word == MIN_RST));

    // R10: with no sample and no read, both words hold
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !rd_max && !rd_min) |=> ($stable(max_word) && $stable(min_word)));

endmodule

bind xd_extremes xd_extremes_chk #(
    .DATA_W (DATA_W),
    .CH_W   (CH_W),
    .WORD_W (WORD_W)
) u_xd_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .smp_chan  (smp_chan),
    .rd_max    (rd_max),
    .rd_min    (rd_min),
    .max_word  (max_word),
    .min_word  (min_word)
);

// File: tb/test_xd_extremes.sv
`timescale 1ns/1ps
module test_xd_extremes;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [23:0] smp_data = '0;
    logic [2:0]  smp_chan = '0;
    logic        rd_max = 1'b0;
    logic        rd_min = 1'b0;
    logic [31:0] max_word;
    logic [31:0] min_word;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [31:0] MAX_RST = 32'h8000_0000;
    localparam logic [31:0] MIN_RST = 32'h7FFF_FF00;

    always #2 clk = ~clk;

    xd_extremes i_xd_extremes (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_chan  (smp_chan),
        .rd_max    (rd_max),
        .rd_min    (rd_min),
        .max_word  (max_word),
        .min_word  (min_word)
    );

    // Packed word: value in 31:8, zero gap 7:3, tag 2:0 (R2).
    function automatic logic [31:0] mk(input logic [23:0] v, input logic [2:0] c);
        return {v, 5'b0, c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs during the low phase.
    task automatic drive(input logic v, input logic [23:0] d, input logic [2:0] c,
                         input logic rmx, input logic rmn);
        @(negedge clk);
        smp_valid = v; smp_data = d; smp_chan = c; rd_max = rmx; rd_min = rmn;
        #1;
    endtask

    // Pass the rising edge, then return the inputs to idle.
    task automatic tick();
        @(posedge clk);
        #1;
        smp_valid = 1'b0; rd_max = 1'b0; rd_min = 1'b0;
    endtask

    task automatic push(input logic [23:0] d, input logic [2:0] c);
        drive(1'b1, d, c, 1'b0, 1'b0);
        tick();
    endtask

    task automatic t_reset();
        check("R1 max reset", max_word, MAX_RST);
        check("R1 min reset", min_word, MIN_RST);
    endtask

    task automatic t_basic();
        push(24'd100, 3'd1);
        check("R9 first sample max", max_word, mk(24'd100, 3'd1));
        check("R9 first sample min", min_word, mk(24'd100, 3'd1));
        push(-24'sd50, 3'd2);
        check("R4 min lower", min_word, mk(-24'sd50, 3'd2));
        check("R3 max kept", max_word, mk(24'd100, 3'd1));
        push(24'd300, 3'd3);
        check("R3 max higher", max_word, mk(24'd300, 3'd3));
        push(24'd200, 3'd4);
        check("R3 between no change", max_word, mk(24'd300, 3'd3));
        check("R4 between no change", min_word, mk(-24'sd50, 3'd2));
        check("R2 gap zero", {27'd0, max_word[7:3]} | {27'd0, min_word[7:3]}, 32'd0);
    endtask

    task automatic t_equal();
        push(24'd300, 3'd5);
        check("R5 equal max tag", max_word, mk(24'd300, 3'd3));
        push(-24'sd50, 3'd6);
        check("R5 equal min tag", min_word, mk(-24'sd50, 3'd2));
    endtask

    task automatic t_idle();
        drive(1'b0, 24'h7FFFFF, 3'd7, 1'b0, 1'b0);
        tick();
        drive(1'b0, 24'h800000, 3'd7, 1'b0, 1'b0);
        tick();
        check("R10 idle max", max_word, mk(24'd300, 3'd3));
        check("R10 idle min", min_word, mk(-24'sd50, 3'd2));
    endtask

    task automatic t_read_max();
        drive(1'b0, 24'd0, 3'd0, 1'b1, 1'b0);
        check("R6 read shows max", max_word, mk(24'd300, 3'd3));
        tick();
        check("R6 max rearmed", max_word, MAX_RST);
        check("R9 min untouched by max read", min_word, mk(-24'sd50, 3'd2));
    endtask

    task automatic t_read_min();
        drive(1'b0, 24'd0, 3'd0, 1'b0, 1'b1);
        check("R7 read shows min", min_word, mk(-24'sd50, 3'd2));
        tick();
        check("R7 min rearmed", min_word, MIN_RST);
        check("R9 max untouched by min read", max_word, MAX_RST);
    endtask

    task automatic t_collide();
        push(24'd50, 3'd2);
        drive(1'b1, 24'd20, 3'd7, 1'b1, 1'b0);
        check("R8 read shows pre-sample", max_word, mk(24'd50, 3'd2));
        tick();
        check("R8 sample kept after read", max_word, mk(24'd20, 3'd7));
        check("R8 other tracker updated", min_word, mk(24'd20, 3'd7));
        drive(1'b1, 24'd10, 3'd4, 1'b0, 1'b1);
        check("R8 min read pre-sample", min_word, mk(24'd20, 3'd7));
        tick();
        check("R8 min keeps sample", min_word, mk(24'd10, 3'd4));
    endtask

    task automatic t_endpoints();
        drive(1'b0, 24'd0, 3'd0, 1'b1, 1'b1);
        tick();
        push(24'h800000, 3'd4);
        check("R5 start value no max update", max_word, MAX_RST);
        check("R4 most negative min", min_word, mk(24'h800000, 3'd4));
        push(24'h7FFFFF, 3'd6);
        check("R3 most positive max", max_word, mk(24'h7FFFFF, 3'd6));
        drive(1'b1, 24'h7FFFFF, 3'd1, 1'b0, 1'b1);
        tick();
        check("R5 start value after min read", min_word, MIN_RST);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_basic();
        t_equal();
        t_idle();
        t_read_max();
        t_read_min();
        t_collide();
        t_endpoints();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule